// File: doc/BRIEF.md
# Power-Mode Peripheral Clock Gating Controller

This block decides, peripheral by peripheral, which clocks run. It holds one enable word for each of the three power states (run, sleep, deep-sleep). A small register port lets software read and write these words. From the power state reported by the chip and a global auto-gating control input, the block picks one of the three words as the active enable vector. Each bit of that vector drives a latch-based clock gate, so every peripheral gets a clean gated clock and a matching enable with no runt pulses.

The block also checks peripheral bus accesses. When an access names a peripheral whose clock is off in the current cycle, the block raises a fault flag so the bus can end the transfer with an error instead of data. Peripheral index i matches bit i of every enable word. The writable bits are 0 to 8 (nine general-purpose I/O ports), bit 13 (DMA engine) and bit 16 (USB controller). The mask is 32'h0001_21FF.

Top module: `clk_gate_ctrl`

## Requirements
- R1: After a synchronous reset, all three enable words read 0 and every `pclk_en` bit is 0.
- R2: Only the bits in mask 32'h0001_21FF can be written. Every other bit of every enable word always reads 0.
- R3: The run word is at offset 0x0, the sleep word at 0x4 and the deep-sleep word at 0x8. Each word keeps its own value, and `reg_rdata` returns it in the same cycle that `reg_rd` is high. `reg_rdata` is 0 when `reg_rd` is low.
- R4: Any other offset reads as 0, and a write to it changes none of the three words.
- R5: While `auto_gate` is 0, the active vector is the run word for every `pwr_mode` value.
- R6: While `auto_gate` is 1, the active vector depends on `pwr_mode`. 2'b01 selects the sleep word. 2'b10 selects the deep-sleep word. 2'b00 and 2'b11 select the run word.
- R7: The active vector registers its selection. A change of mode, of `auto_gate` or of a word appears on `pclk_en` one cycle after the change.
- R8: `acc_fault` is 1 exactly when `acc_req` is 1 and bit `acc_id` of the active vector is 0. This includes every peripheral index outside the writable mask.
- R9: Suppose a write enables a peripheral in cycle c. An access to that peripheral in cycle c+1 still faults. From cycle c+2 on, the access does not fault.
- R10: Each `pclk_en` bit comes from a latch that is open only while `clk` is low. `pclk[i]` equals `clk` AND `pclk_en[i]`, so a gated clock is high during the high phase only for enabled peripherals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, same cycle as the strobe |
| pwr_mode | input | 2 | Power state: 00 run, 01 sleep, 10 deep-sleep |
| auto_gate | input | 1 | 1 lets the sleep and deep-sleep words take effect |
| acc_req | input | 1 | A peripheral access is in progress |
| acc_id | input | 5 | Index of the peripheral being accessed |
| acc_fault | output | 1 | The access targets an unclocked peripheral |
| pclk_en | output | 32 | Glitch-free clock enable for each peripheral |
| pclk | output | 32 | Gated clock for each peripheral |

## Verification
The hardest case to reach is the one-cycle window after a write that enables a peripheral. The word already holds the new bit, but the active vector does not yet have it, so an access must still fault. The bench writes the word and, in the very next cycle, presents an access to the newly enabled index and expects a fault. It then repeats the access one cycle later and expects none. Reaching the sleep and deep-sleep selections requires loading three distinct words first, then stepping through every combination of `auto_gate` and mode. The bench samples `pclk_en` both before and after the update edge.

// File: rtl/cgc_pkg.sv
package cgc_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'b00,
        PM_SLEEP = 2'b01,
        PM_DEEP  = 2'b10,
        PM_RSVD  = 2'b11
    } pmode_e;

    localparam int NUM_BANKS = 3;
    localparam int BANK_RUN   = 0;
    localparam int BANK_SLEEP = 1;
    localparam int BANK_DEEP  = 2;

    // Bank picked by the auto-gating control and the current power state.
    function automatic int unsigned pick_bank(input logic ag, input pmode_e m);
        if (!ag)             return BANK_RUN;
        else if (m == PM_SLEEP) return BANK_SLEEP;
        else if (m == PM_DEEP)  return BANK_DEEP;
        else                    return BANK_RUN;
    endfunction

endpackage

// File: rtl/cgc_regfile.sv
module cgc_regfile
    import cgc_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter int          ADDR_W  = 4,
    parameter logic [DATA_W-1:0] WR_MASK = 32'h0001_21FF
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr,
    input  logic                               rd,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [DATA_W-1:0]                  wdata,
    output logic [DATA_W-1:0]                  rdata,
    output logic [NUM_BANKS-1:0][DATA_W-1:0]   bank
);
    localparam int STRIDE = DATA_W / 8;

    logic [NUM_BANKS-1:0] hit;

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        assign hit[k] = (addr == ADDR_W'(k * STRIDE));
        always_ff @(posedge clk) begin
            if (rst)
                bank[k] <= '0;
            else if (wr && hit[k])
                bank[k] <= wdata & WR_MASK;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            for (int k = 0; k < NUM_BANKS; k++)
                if (hit[k]) rdata = bank[k];
        end
    end
endmodule

// File: rtl/cgc_mode_sel.sv
module cgc_mode_sel
    import cgc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             ag,
    input  pmode_e                           mode,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0] bank,
    output logic [DATA_W-1:0]                active
);
    logic [DATA_W-1:0] next_active;

    always_comb next_active = bank[pick_bank(ag, mode)];

    always_ff @(posedge clk) begin
        if (rst) active <= '0;
        else     active <= next_active;
    end
endmodule

// File: rtl/cgc_gate_cell.sv
module cgc_gate_cell (
    input  logic clk,
    input  logic en,
    output logic en_l,
    output logic gclk
);
    // Transparent while the clock is low; frozen during the high phase.
    always_latch begin
        if (!clk) en_l = en;
    end

    assign gclk = clk & en_l;
endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl
    import cgc_pkg::*;
#(
    parameter int                DATA_W  = 32,
    parameter int                ADDR_W  = 4,
    parameter logic [DATA_W-1:0] WR_MASK = 32'h0001_21FF,
    localparam int               ID_W    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [1:0]        pwr_mode,
    input  logic              auto_gate,
    input  logic              acc_req,
    input  logic [ID_W-1:0]   acc_id,
    output logic              acc_fault,
    output logic [DATA_W-1:0] pclk_en,
    output logic [DATA_W-1:0] pclk
);
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_q;
    logic [DATA_W-1:0]                active_q;

    cgc_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WR_MASK(WR_MASK)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .bank(bank_q)
    );

    cgc_mode_sel #(.DATA_W(DATA_W)) u_sel (
        .clk(clk), .rst(rst), .ag(auto_gate), .mode(pmode_e'(pwr_mode)),
        .bank(bank_q), .active(active_q)
    );

    for (genvar i = 0; i < DATA_W; i++) begin : g_gate
        if (WR_MASK[i]) begin : g_live
            cgc_gate_cell u_cell (
                .clk(clk), .en(active_q[i]), .en_l(pclk_en[i]), .gclk(pclk[i])
            );
        end else begin : g_tied
            assign pclk_en[i] = 1'b0;
            assign pclk[i]    = 1'b0;
        end
    end

    // Fault decision uses the registered vector of the current cycle.
    assign acc_fault = acc_req && !active_q[acc_id];
endmodule

// File: rtl/cgc_checker.sv
module cgc_checker
    import cgc_pkg::*;
#(
    parameter int                DATA_W  = 32,
    parameter logic [DATA_W-1:0] WR_MASK = 32'h0001_21FF,
    localparam int               ID_W    = $clog2(DATA_W)
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             reg_rd,
    input logic [DATA_W-1:0]                reg_rdata,
    input logic [1:0]                       pwr_mode,
    input logic                             auto_gate,
    input logic                             acc_req,
    input logic [ID_W-1:0]                  acc_id,
    input logic                             acc_fault,
    input logic [DATA_W-1:0]                pclk_en,
    input logic [DATA_W-1:0]                active_q,
    input logic [NUM_BANKS-1:0][DATA_W-1:0] bank_q
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (active_q == '0 && bank_q == '0));

    p_ro_bits_zero_r2: assert property (@(posedge clk) disable iff (rst)
        reg_rd |-> ((reg_rdata & ~WR_MASK) == '0));

    p_run_only_r5: assert property (@(posedge clk) disable iff (rst)
        !auto_gate |=> active_q == $past(bank_q[BANK_RUN]));

    p_sleep_pick_r6: assert property (@(posedge clk) disable iff (rst)
        (auto_gate && pwr_mode == 2'b01) |=> active_q == $past(bank_q[BANK_SLEEP]));

    p_deep_pick_r6: assert property (@(posedge clk) disable iff (rst)
        (auto_gate && pwr_mode == 2'b10) |=> active_q == $past(bank_q[BANK_DEEP]));

    p_fault_needs_req_r8: assert property (@(posedge clk) disable iff (rst)
        acc_fault |-> acc_req);

    p_grant_when_clocked_r8: assert property (@(posedge clk) disable iff (rst)
        (acc_req && pclk_en[acc_id]) |-> !acc_fault);

    p_latch_tracks_r10: assert property (@(posedge clk) disable iff (rst)
        pclk_en == active_q);
endmodule

bind clk_gate_ctrl cgc_checker #(.DATA_W(DATA_W), .WR_MASK(WR_MASK)) u_chk (.*);

// File: tb/clk_gate_ctrl_test.sv
module clk_gate_ctrl_test;
    localparam logic [31:0] MASK  = 32'h0001_21FF;
    localparam logic [31:0] W_RUN = 32'h0000_0005;
    localparam logic [31:0] W_SLP = 32'h0001_0100;
    localparam logic [31:0] W_DP  = 32'h0000_2080;

    // {auto_gate, pwr_mode, expected active vector}
    localparam int NV = 8;
    localparam logic [34:0] VEC [NV] = '{
        {1'b0, 2'b00, W_RUN}, {1'b0, 2'b01, W_RUN}, {1'b0, 2'b10, W_RUN},
        {1'b0, 2'b11, W_RUN}, {1'b1, 2'b00, W_RUN}, {1'b1, 2'b01, W_SLP},
        {1'b1, 2'b10, W_DP }, {1'b1, 2'b11, W_RUN}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  pwr_mode = 2'b00;
    logic        auto_gate = 1'b0;
    logic        acc_req = 1'b0;
    logic [4:0]  acc_id = '0;
    logic        acc_fault;
    logic [31:0] pclk_en, pclk;

    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    clk_gate_ctrl uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwr_mode(pwr_mode),
        .auto_gate(auto_gate), .acc_req(acc_req), .acc_id(acc_id),
        .acc_fault(acc_fault), .pclk_en(pclk_en), .pclk(pclk)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic next_cycle();
        @(posedge clk); #1;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        next_cycle();
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
        reg_rd = 1'b1; reg_addr = a; #1;
        check(req, reg_rdata, exp);
        reg_rd = 1'b0; #1;
    endtask

    task automatic en_at_low(input string req, input logic [31:0] exp);
        @(negedge clk); #1;
        check(req, pclk_en, exp);
        next_cycle();
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) next_cycle();
        rst = 1'b0;

        // R1 reset state
        rd_check("R1", 4'h0, 32'h0);
        rd_check("R1", 4'h4, 32'h0);
        rd_check("R1", 4'h8, 32'h0);
        @(negedge clk); #1; check("R1", pclk_en, 32'h0);
        next_cycle();

        // R2 write mask
        wr_reg(4'h0, 32'hFFFF_FFFF);
        rd_check("R2", 4'h0, MASK);

        // R3 independent words at their offsets
        wr_reg(4'h0, W_RUN | 32'hFF00_0000);
        wr_reg(4'h4, W_SLP);
        wr_reg(4'h8, W_DP);
        rd_check("R3", 4'h0, W_RUN);
        rd_check("R3", 4'h4, W_SLP);
        rd_check("R3", 4'h8, W_DP);
        reg_addr = 4'h0; #1; check("R3", reg_rdata, 32'h0);

        // R4 undefined offsets
        wr_reg(4'hC, 32'hFFFF_FFFF);
        wr_reg(4'h2, 32'hFFFF_FFFF);
        rd_check("R4", 4'hC, 32'h0);
        rd_check("R4", 4'h2, 32'h0);
        rd_check("R4", 4'h0, W_RUN);
        rd_check("R4", 4'h4, W_SLP);
        rd_check("R4", 4'h8, W_DP);

        // R5 / R6 table walk
        for (int v = 0; v < NV; v++) begin
            auto_gate = VEC[v][34];
            pwr_mode  = VEC[v][33:32];
            next_cycle();
            en_at_low(VEC[v][34] ? "R6" : "R5", VEC[v][31:0]);
        end

        // R7 one-cycle delay after mode change (now ag=1, mode=11 -> run)
        auto_gate = 1'b1; pwr_mode = 2'b10;
        @(negedge clk); #1; check("R7", pclk_en, W_RUN);
        next_cycle();
        en_at_low("R7", W_DP);

        // R10 gated clock phases (deep word active: bits 7 and 13)
        @(posedge clk); #5;
        check("R10", pclk, W_DP);
        @(negedge clk); #1;
        check("R10", pclk, 32'h0);
        next_cycle();

        // R8 fault decision on run word
        auto_gate = 1'b0; pwr_mode = 2'b00;
        next_cycle(); next_cycle();
        acc_req = 1'b1;
        acc_id = 5'd0;  #1; check("R8", {31'b0, acc_fault}, 32'h0);
        acc_id = 5'd1;  #1; check("R8", {31'b0, acc_fault}, 32'h1);
        acc_id = 5'd20; #1; check("R8", {31'b0, acc_fault}, 32'h1);
        acc_req = 1'b0; #1; check("R8", {31'b0, acc_fault}, 32'h0);

        // R9 access right after enabling write
        wr_reg(4'h0, W_RUN | 32'h2);
        acc_req = 1'b1; acc_id = 5'd1; #1;
        check("R9", {31'b0, acc_fault}, 32'h1);
        next_cycle();
        check("R9", {31'b0, acc_fault}, 32'h0);
        acc_req = 1'b0;

        // R1 reset again clears everything
        rst = 1'b1; next_cycle(); next_cycle(); rst = 1'b0;
        rd_check("R1", 4'h0, 32'h0);
        en_at_low("R1", 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule